// File: doc/BRIEF.md
# Regulator Fault Status Serial Port

This block is the status read-back port of a multi-rail regulator. It watches four supply outputs: one sensor rail and three reference rails. For each rail it reports two flags to a host over a four-wire serial link. The thermal flag is sticky: it records whether that rail hit its thermal limit at any point since the last transfer. The current flag is live: it shows whether that rail is in current limit at the moment the transfer starts.

The host selects the block by pulling the active-low chip select. The block then takes a snapshot of the 16-bit status word. It shifts the word out most significant bit first, changing MISO after each falling SCLK edge so that the host can sample it on the rising edge. When chip select goes back high, the sticky thermal flags are cleared. The clear applies even when the frame was short. A thermal event that occurs while the frame is in progress is carried over into the next report, so it is not lost. A one-cycle strobe marks every frame that carried exactly 16 clocks.

SCLK, chip select and MOSI are brought into the system clock domain through two-flop synchronizers. The fault inputs are synchronous to the system clock and are active high. Bits shifted in from MOSI only refill the shift register behind the outgoing word; no command is decoded.

Top module: `rail_fault_spi`

## Requirements
- R1: After reset, MISO and frame_done are 0 and all thermal latches are clear. The first frame after reset therefore reads 0x0000 when no fault input is active.
- R2: The status word is laid out as follows:
  - Bits 15..8 read as 0.
  - Bits 7..4 are the thermal flags of sensor, ref3, ref2 and ref1, in that order.
  - Bits 3..0 are the current flags in the same rail order.
  - Input vectors map to rails by index: index 3 is sensor, 2 is ref3, 1 is ref2 and 0 is ref1.
- R3: The word is captured when chip select falls. It leaves MISO MSB first. Bit 15 is present before the first rising SCLK edge, and each following bit appears after a falling SCLK edge.
- R4: A single-cycle pulse on a thermal input sets that rail's thermal flag. The flag stays set while no frame ends.
- R5: The rising edge of chip select clears every thermal latch that had no event during the frame.
- R6: A current flag shows the current-limit input at the time of capture. A limit that has gone away before the frame starts reads 0.
- R7: frame_done pulses for exactly one clock after a frame that held exactly 16 rising SCLK edges. It stays 0 for any other count.
- R8: A thermal event that arrives after capture and before chip select rises is not cleared. It appears in the next frame.
- R9: A frame with fewer than 16 clocks still clears the thermal latches.
- R10: MISO is 0 whenever the block is not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| therm_hit | input | 4 | Thermal limit event per rail (3 sensor .. 0 ref1) |
| ilim_on | input | 4 | Current limit condition per rail (3 sensor .. 0 ref1) |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial status data to host |
| frame_done | output | 1 | One-cycle strobe after a 16-clock frame |

## Verification
Every serial pin passes through two synchronizer flops and one edge-detect flop before it acts. The capture, each shift and the thermal clear therefore take effect three system clocks after the pin edge that causes them. frame_done rises on that same third clock. The bench holds each SCLK phase for eight system clocks, and it waits six clocks after chip select falls before it reads anything. As a result, every MISO sample is taken well after the data has settled. The strobe is counted over the whole window after each frame rather than in one exact cycle.

// File: rtl/rail_fault_spi.sv
module rail_fault_spi (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] therm_hit,
  input  logic [3:0] ilim_on,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       miso,
  output logic       frame_done
);
  localparam int WORD = 16;
  localparam int CW   = $clog2(WORD) + 1;

  logic [2:0] cs_q, sk_q;
  logic [1:0] mo_q;
  logic       rx_bit, active;
  logic [3:0] lat, pend;
  logic [WORD-1:0] shreg;
  logic [CW-1:0]   cnt;

  wire cs_fall = cs_q[2] & ~cs_q[1];
  wire cs_rise = ~cs_q[2] & cs_q[1];
  wire sk_rise = active & sk_q[1] & ~sk_q[2];
  wire sk_fall = active & ~sk_q[1] & sk_q[2];

  assign miso = active & shreg[WORD-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q <= '1;
      sk_q <= '0;
      mo_q <= '0;
    end else begin
      cs_q <= {cs_q[1:0], cs_n};
      sk_q <= {sk_q[1:0], sclk};
      mo_q <= {mo_q[0], mosi};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat  <= '0;
      pend <= '0;
    end else if (cs_rise) begin
      lat  <= pend | therm_hit;
      pend <= '0;
    end else if (cs_fall) begin
      lat  <= lat | therm_hit;
      pend <= therm_hit;
    end else begin
      lat  <= lat | therm_hit;
      pend <= pend | therm_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      shreg      <= '0;
      cnt        <= '0;
      rx_bit     <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= cs_rise && active && (cnt == CW'(WORD));
      if (cs_fall) begin
        active <= 1'b1;
        shreg  <= {8'h00, lat | therm_hit, ilim_on};
        cnt    <= '0;
      end else if (cs_rise) begin
        active <= 1'b0;
      end else begin
        if (sk_rise) begin
          rx_bit <= mo_q[1];
          if (cnt != '1) cnt <= cnt + 1'b1;
        end
        if (sk_fall) shreg <= {shreg[WORD-2:0], rx_bit};
      end
    end
  end

  a_r4_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> ((lat & $past(lat)) == $past(lat)));
  a_r5_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && pend == 4'b0 && therm_hit == 4'b0) |=> (lat == 4'b0));
  a_r8_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_hit != 4'b0) |=> ((lat & $past(therm_hit)) == $past(therm_hit)));
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q[2] && !active) |-> (miso == 1'b0));
endmodule

// File: tb/sim_rail_fault_spi.sv
module sim_rail_fault_spi;
  logic clk = 0, rst_n = 0;
  logic [3:0] therm_hit = 0, ilim_on = 0;
  logic sclk = 0, cs_n = 1, mosi = 0;
  logic miso, frame_done;
  int total = 0, bad = 0, dones = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rail_fault_spi u0 (.clk(clk), .rst_n(rst_n), .therm_hit(therm_hit), .ilim_on(ilim_on),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso), .frame_done(frame_done));

  always @(posedge clk) if (frame_done) dones++;

  // {therm pulse, ilim level, expected word}
  localparam logic [23:0] VEC [6] = '{
    {4'h0, 4'h0, 16'h0000},
    {4'h8, 4'h0, 16'h0080},
    {4'h0, 4'h5, 16'h0005},
    {4'h3, 4'hC, 16'h003C},
    {4'hF, 4'hF, 16'h00FF},
    {4'h4, 4'h2, 16'h0042}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_therm(input logic [3:0] m);
    @(negedge clk); therm_hit = m;
    @(negedge clk); therm_hit = 0;
  endtask

  task automatic frame(input int nbits, output logic [15:0] word, input logic [3:0] mid_evt = 0);
    word = 0;
    @(negedge clk); cs_n = 0;
    wclk(6);
    for (int i = 0; i < nbits; i++) begin
      wclk(8);
      if (i < 16) word = {word[14:0], miso};
      sclk = 1; mosi = ~mosi;
      wclk(8);
      sclk = 0;
    end
    if (mid_evt != 0) pulse_therm(mid_evt);
    wclk(8);
    cs_n = 1;
    wclk(10);
  endtask

  initial begin
    logic [15:0] w;
    int d0;
    wclk(4);
    check("R1 miso", {15'b0, miso}, 16'h0);
    check("R1 frame_done", {15'b0, frame_done}, 16'h0);
    rst_n = 1;
    wclk(4);
    frame(16, w);
    check("R1 first frame", w, 16'h0000);
    check("R10 idle miso", {15'b0, miso}, 16'h0);

    for (int k = 0; k < 6; k++) begin
      d0 = dones;
      if (VEC[k][23:20] != 0) pulse_therm(VEC[k][23:20]);
      ilim_on = VEC[k][19:16];
      frame(16, w);
      ilim_on = 0;
      check("R2/R3 word", w, VEC[k][15:0]);
      check("R7 strobe 16", 16'(dones - d0), 16'd1);
    end

    pulse_therm(4'h1);
    wclk(60);
    frame(16, w);
    check("R4 sticky", w, 16'h0010);
    frame(16, w);
    check("R5 cleared", w, 16'h0000);

    ilim_on = 4'h6; wclk(5); ilim_on = 0; wclk(5);
    frame(16, w);
    check("R6 live only", w, 16'h0000);

    frame(16, w, 4'h2);
    check("R8 frame before event", w, 16'h0000);
    frame(16, w);
    check("R8 event carried", w, 16'h0020);

    pulse_therm(4'h8);
    d0 = dones;
    frame(5, w);
    check("R9 short read", w, 16'h0000);
    check("R7 no strobe short", 16'(dones - d0), 16'd0);
    frame(16, w);
    check("R9 cleared after short", w, 16'h0000);

    d0 = dones;
    frame(17, w);
    check("R7 no strobe long", 16'(dones - d0), 16'd0);
    check("R10 miso after frame", {15'b0, miso}, 16'h0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule